// File: doc/BRIEF.md
# Capped Node-ID Routing Table

This block is a static routing table for a small point-to-point multiprocessor fabric. Every node has a 3-bit ID that marks it as the source or the destination of coherency packets. Each node is strapped with its own ID. Software also gives it the highest ID in use in the system. A fixed hardware ceiling, set when the part is built, limits how high that system maximum can go. A ceiling of 0, 1, 4 or 7 gives a part that supports 1, 2, 5 or 8 nodes.

A configuration port does two things: it sets the active maximum ID, and it writes one output-link entry for each destination ID. Writes of a maximum above the ceiling are clamped to the ceiling and raise a sticky error. Writes of an entry for a destination above the active maximum are dropped and flagged for one cycle. A lookup port takes a packet's destination ID. In the same cycle it returns the output link, a local-delivery indication for the node's own ID, or an invalid flag when the ID is out of range or has no entry.

Top module: `node_route_table`

## Requirements
- R1: After reset the active maximum is 0, the capping error and reject flag are 0, and every entry is unprogrammed. A lookup of any ID other than the own ID, with that ID at or below 0, is invalid. A reset also clears entries that were written before it.
- R2: A maximum write (`cfgWe`=1, `cfgSelMax`=1) whose value is at or below the ceiling (`CAP_ID`, default 4) sets `activeMax` to that value from the next cycle on.
- R3: A maximum write above the ceiling sets `activeMax` to the ceiling and sets `capErr` from the next cycle. `capErr` then stays 1 until reset, even through later legal maximum writes.
- R4: An entry write (`cfgWe`=1, `cfgSelMax`=0) for destination `cfgId` at or below `activeMax` stores `cfgLink`. From the next cycle a lookup of that ID gives `lkValid`=1, `lkLocal`=0 and `lkLink` equal to the stored link.
- R5: An entry write for a destination above `activeMax` stores nothing, so a later lookup after the maximum is raised is still invalid. `wrReject` is 1 in exactly the one cycle after that write.
- R6: A lookup whose destination is above `activeMax` gives `lkValid`=0, `lkLocal`=0 and `lkLink`=0 in the same cycle, without a clock edge.
- R7: A lookup whose destination equals `ownId` and is at or below `activeMax` gives `lkValid`=1, `lkLocal`=1 and `lkLink`=0, whatever entry is stored for that ID.
- R8: A lookup of an in-range, non-own destination that has never been written gives `lkValid`=0 and `lkLink`=0.
- R9: Lowering `activeMax` hides the stored entries above the new value without erasing them, so raising the maximum again makes them valid with their old links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ownId | input | ID_W | This node's strapped ID |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSelMax | input | 1 | 1: write the maximum ID; 0: write a table entry |
| cfgId | input | ID_W | Maximum value, or destination of the entry |
| cfgLink | input | LINK_W | Output link for an entry write |
| lkDest | input | ID_W | Destination ID to look up |
| lkValid | output | 1 | Lookup result is usable |
| lkLocal | output | 1 | Destination is this node |
| lkLink | output | LINK_W | Output link for the destination |
| activeMax | output | ID_W | Active system maximum ID |
| capErr | output | 1 | Sticky: a maximum above the ceiling was written |
| wrReject | output | 1 | The previous cycle's entry write was refused |

## Verification
The assertions assume that `ownId` stays constant while out of reset and that `cfgSelMax` and `cfgId` are meaningful only while `cfgWe` is 1. They also assume that at most one configuration operation arrives per cycle. The bench ties `ownId` to 2 for the whole run and changes inputs only on the falling clock edge. It drops `cfgWe` after every single-cycle operation, so the properties always see one clean write followed by idle cycles.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic loadMax;   // update the active maximum
    logic clampHit;  // requested maximum exceeded the ceiling
    logic loadEntry; // store one table entry
    logic rejectWr;  // entry write refused
  } nrtStrobe_t;
endpackage

// File: rtl/nrt_ctrl.sv
module nrt_ctrl
  import nrt_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int CAP_ID = 4
) (
  input  logic            cfgWe,
  input  logic            cfgSelMax,
  input  logic [ID_W-1:0] cfgId,
  input  logic [ID_W-1:0] activeMax,
  output nrtStrobe_t      strb,
  output logic [ID_W-1:0] maxVal
);
  localparam logic [ID_W-1:0] CapV = ID_W'(CAP_ID);

  logic overCap;
  logic outOfRange;

  always_comb begin
    overCap    = cfgId > CapV;
    outOfRange = cfgId > activeMax;
    maxVal     = overCap ? CapV : cfgId;

    strb           = '0;
    strb.loadMax   = cfgWe & cfgSelMax;
    strb.clampHit  = cfgWe & cfgSelMax & overCap;
    strb.loadEntry = cfgWe & ~cfgSelMax & ~outOfRange;
    strb.rejectWr  = cfgWe & ~cfgSelMax & outOfRange;
  end
endmodule

// File: rtl/nrt_datapath.sv
module nrt_datapath
  import nrt_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int LINK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  nrtStrobe_t        strb,
  input  logic [ID_W-1:0]   maxVal,
  input  logic [ID_W-1:0]   cfgId,
  input  logic [LINK_W-1:0] cfgLink,
  input  logic [ID_W-1:0]   ownId,
  input  logic [ID_W-1:0]   lkDest,
  output logic [ID_W-1:0]   activeMax,
  output logic              capErr,
  output logic              wrReject,
  output logic              lkValid,
  output logic              lkLocal,
  output logic [LINK_W-1:0] lkLink
);
  localparam int Nodes = 1 << ID_W;

  logic [Nodes-1:0]  entryVld;
  logic [LINK_W-1:0] entryLink [Nodes];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMax <= '0;
      capErr    <= 1'b0;
      wrReject  <= 1'b0;
    end else begin
      if (strb.loadMax) activeMax <= maxVal;
      if (strb.clampHit) capErr <= 1'b1;
      wrReject <= strb.rejectWr;
    end
  end

  for (genvar g = 0; g < Nodes; g++) begin : gEntry
    logic hitG;
    assign hitG = strb.loadEntry && (cfgId == ID_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryVld[g]  <= 1'b0;
        entryLink[g] <= '0;
      end else if (hitG) begin
        entryVld[g]  <= 1'b1;
        entryLink[g] <= cfgLink;
      end
    end
  end

  logic inRange;
  logic isOwn;
  logic remoteHit;

  always_comb begin
    inRange   = lkDest <= activeMax;
    isOwn     = lkDest == ownId;
    remoteHit = inRange & ~isOwn & entryVld[lkDest];
    lkLocal   = inRange & isOwn;
    lkValid   = lkLocal | remoteHit;
    lkLink    = remoteHit ? entryLink[lkDest] : '0;
  end
endmodule

// File: rtl/node_route_table.sv
module node_route_table
  import nrt_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int LINK_W = 2,
  parameter int CAP_ID = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   ownId,
  input  logic              cfgWe,
  input  logic              cfgSelMax,
  input  logic [ID_W-1:0]   cfgId,
  input  logic [LINK_W-1:0] cfgLink,
  input  logic [ID_W-1:0]   lkDest,
  output logic              lkValid,
  output logic              lkLocal,
  output logic [LINK_W-1:0] lkLink,
  output logic [ID_W-1:0]   activeMax,
  output logic              capErr,
  output logic              wrReject
);
  nrtStrobe_t      strb;
  logic [ID_W-1:0] maxVal;

  nrt_ctrl #(.ID_W(ID_W), .CAP_ID(CAP_ID)) uCtrl (
    .cfgWe(cfgWe), .cfgSelMax(cfgSelMax), .cfgId(cfgId),
    .activeMax(activeMax), .strb(strb), .maxVal(maxVal)
  );

  nrt_datapath #(.ID_W(ID_W), .LINK_W(LINK_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .maxVal(maxVal),
    .cfgId(cfgId), .cfgLink(cfgLink), .ownId(ownId), .lkDest(lkDest),
    .activeMax(activeMax), .capErr(capErr), .wrReject(wrReject),
    .lkValid(lkValid), .lkLocal(lkLocal), .lkLink(lkLink)
  );
endmodule

// File: rtl/nrt_checker.sv
module nrt_checker #(
  parameter int ID_W   = 3,
  parameter int LINK_W = 2,
  parameter int CAP_ID = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ID_W-1:0]   ownId,
  input logic              cfgWe,
  input logic              cfgSelMax,
  input logic [ID_W-1:0]   cfgId,
  input logic [ID_W-1:0]   lkDest,
  input logic              lkValid,
  input logic              lkLocal,
  input logic [LINK_W-1:0] lkLink,
  input logic [ID_W-1:0]   activeMax,
  input logic              capErr,
  input logic              wrReject
);
  localparam logic [ID_W-1:0] CapV = ID_W'(CAP_ID);

  AST_MAX_UNDER_CAP: assert property (@(posedge clk) disable iff (!rstN)
    activeMax <= CapV); // R3
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    capErr |=> capErr); // R3
  AST_CAP_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSelMax && cfgId > CapV) |=> (capErr && activeMax == CapV)); // R3
  AST_MAX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSelMax && cfgId <= CapV) |=> (activeMax == $past(cfgId))); // R2
  AST_ENTRY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgSelMax && cfgId > activeMax) |=> wrReject); // R5
  AST_NO_FALSE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && !cfgSelMax && cfgId > activeMax) |=> !wrReject); // R5
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (lkDest > activeMax) |-> (!lkValid && !lkLocal && lkLink == '0)); // R6
  AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (lkDest == ownId && lkDest <= activeMax) |-> (lkValid && lkLocal && lkLink == '0)); // R7
endmodule

bind node_route_table nrt_checker #(.ID_W(ID_W), .LINK_W(LINK_W), .CAP_ID(CAP_ID)) uChk (
  .clk(clk), .rstN(rstN), .ownId(ownId), .cfgWe(cfgWe), .cfgSelMax(cfgSelMax),
  .cfgId(cfgId), .lkDest(lkDest), .lkValid(lkValid), .lkLocal(lkLocal),
  .lkLink(lkLink), .activeMax(activeMax), .capErr(capErr), .wrReject(wrReject)
);

// File: tb/sim_node_route_table.sv
module sim_node_route_table;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // {req[21:18], op[17:16] (0 idle,1 max,2 entry), id[15:13], link[12:11],
  //  dest[10:8], expValid[7], expLocal[6], expLink[5:4], expMax[3:1], expRej[0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd8, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0}, // R8 unwritten id0
    {4'd5, 2'd2, 3'd1, 2'd3, 3'd1, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1}, // R5 entry1 above max
    {4'd5, 2'd1, 3'd3, 2'd0, 3'd1, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0}, // R5 still empty after raise
    {4'd4, 2'd2, 3'd1, 2'd3, 3'd1, 1'b1, 1'b0, 2'd3, 3'd3, 1'b0}, // R4
    {4'd4, 2'd2, 3'd0, 2'd1, 3'd0, 1'b1, 1'b0, 2'd1, 3'd3, 1'b0}, // R4
    {4'd7, 2'd0, 3'd0, 2'd0, 3'd2, 1'b1, 1'b1, 2'd0, 3'd3, 1'b0}, // R7 own id
    {4'd7, 2'd2, 3'd2, 2'd3, 3'd2, 1'b1, 1'b1, 2'd0, 3'd3, 1'b0}, // R7 entry ignored for own
    {4'd8, 2'd0, 3'd0, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0}, // R8
    {4'd6, 2'd0, 3'd0, 2'd0, 3'd4, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0}, // R6
    {4'd2, 2'd1, 3'd1, 2'd0, 3'd1, 1'b1, 1'b0, 2'd3, 3'd1, 1'b0}, // R2 lower max
    {4'd6, 2'd0, 3'd0, 2'd0, 3'd2, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0}, // R6 own above max
    {4'd9, 2'd1, 3'd3, 2'd0, 3'd2, 1'b1, 1'b1, 2'd0, 3'd3, 1'b0}, // R9
    {4'd4, 2'd2, 3'd3, 2'd2, 3'd3, 1'b1, 1'b0, 2'd2, 3'd3, 1'b0}, // R4
    {4'd9, 2'd1, 3'd1, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0}, // R9 hidden
    {4'd9, 2'd1, 3'd3, 2'd0, 3'd3, 1'b1, 1'b0, 2'd2, 3'd3, 1'b0}, // R9 restored
    {4'd3, 2'd1, 3'd7, 2'd0, 3'd4, 1'b0, 1'b0, 2'd0, 3'd4, 1'b0}, // R3 clamp to 4
    {4'd4, 2'd2, 3'd4, 2'd1, 3'd4, 1'b1, 1'b0, 2'd1, 3'd4, 1'b0}, // R4
    {4'd5, 2'd2, 3'd5, 2'd0, 3'd5, 1'b0, 1'b0, 2'd0, 3'd4, 1'b1}  // R5 above clamped max
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] ownId = 3'd2;
  logic       cfgWe = 1'b0;
  logic       cfgSelMax = 1'b0;
  logic [2:0] cfgId = '0;
  logic [1:0] cfgLink = '0;
  logic [2:0] lkDest = '0;
  logic       lkValid, lkLocal, capErr, wrReject;
  logic [1:0] lkLink;
  logic [2:0] activeMax;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  node_route_table u0 (
    .clk(clk), .rstN(rstN), .ownId(ownId), .cfgWe(cfgWe), .cfgSelMax(cfgSelMax),
    .cfgId(cfgId), .cfgLink(cfgLink), .lkDest(lkDest), .lkValid(lkValid),
    .lkLocal(lkLocal), .lkLink(lkLink), .activeMax(activeMax), .capErr(capErr),
    .wrReject(wrReject)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle config operation, then idle with a lookup
  task automatic doOp(input logic [1:0] op, input logic [2:0] id, input logic [1:0] link);
    @(negedge clk);
    cfgWe = (op != 2'd0);
    cfgSelMax = (op == 2'd1);
    cfgId = id;
    cfgLink = link;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 activeMax", 16'(activeMax), 16'd0);
    check("R1 capErr/wrReject", 16'({capErr, wrReject}), 16'd0);
    for (int d = 0; d < 8; d++) begin
      lkDest = 3'(d);
      #1;
      check("R1 lookup after reset", 16'({lkValid, lkLocal, lkLink}), 16'd0);
    end

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][17:16], VEC[i][15:13], VEC[i][12:11]);
      lkDest = VEC[i][10:8];
      #1;
      nChecks++;
      if ({lkValid, lkLocal, lkLink, activeMax, wrReject} !== VEC[i][7:0]) begin
        nFails++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b", VEC[i][21:18], i,
                 {lkValid, lkLocal, lkLink, activeMax, wrReject}, VEC[i][7:0]);
      end
    end

    // R5 reject pulse lasts one cycle
    @(negedge clk);
    check("R5 wrReject single cycle", 16'(wrReject), 16'd0);
    // R3 sticky error through a legal max write
    check("R3 capErr set", 16'(capErr), 16'd1);
    doOp(2'd1, 3'd2, 2'd0);
    check("R2 legal max after clamp", 16'(activeMax), 16'd2);
    check("R3 capErr stays set", 16'(capErr), 16'd1);
    // R6 same-cycle invalid on lookup change
    lkDest = 3'd3;
    #1;
    check("R6 combinational invalid", 16'({lkValid, lkLink}), 16'd0);
    lkDest = 3'd1;
    #1;
    check("R9 entry1 visible", 16'({lkValid, lkLink}), 16'b111);

    // R1 reset clears entries
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 capErr cleared", 16'(capErr), 16'd0);
    doOp(2'd1, 3'd3, 2'd0);
    lkDest = 3'd1;
    #1;
    check("R1 entry cleared by reset", 16'({lkValid, lkLink}), 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule